// File: doc/BRIEF.md
# Sidetone Filter Coefficient Loader and Control Registers

This block is the register front end of an audio sidetone filter. A 32-bit register bus reaches a small set of control registers: a fixed revision word, a system configuration word that carries the clock auto-idle permission, a one-bit interrupt status and enable pair, a packed two-channel gain word and a control word. The block drives the filter's enable, the gain values and the auto-idle request straight out of these registers.

A single port address fills the filter's 128-entry table of signed 16-bit taps. Software raises the control register's coefficient-write-enable bit. It then writes the taps one after another to the port address, and the block hands each accepted word to the coefficient RAM write port with an address that counts up from zero. Once the last tap is stored, a read-only done flag rises for software to poll, and the load-complete interrupt status bit is set. Software then lowers the write-enable bit. Raising the bit again starts a fresh load.

The bus uses a single-cycle write strobe. Read data is combinational from the address. All state is reset synchronously by an active-low reset.

Top module: `sidetone_ctrl`

## Requirements
- R1: When reset is held low at a clock edge, every register is cleared at that edge: gains, sidetone enable, auto-idle, interrupt status, interrupt enable, write-enable, done flag and tap counter. Afterwards the control word (offset 0x2C) reads 0 and the irq output is low.
- R2: Offset 0x00 always reads the REV_ID constant. Writes to it change nothing.
- R3: A write to offset 0x24 loads gain_ch0 from bits 15:0 and gain_ch1 from bits 31:16. Both outputs show the new values from the clock edge that accepts the write.
- R4: Bit 0 of the control word (0x2C) drives tone_en. Bit 0 of the configuration word (0x10) drives auto_idle. Both read back at their positions.
- R5: A control write that takes bit 1 (write-enable) from 0 to 1 resets the tap address to 0 and clears the done flag (control bit 2).
- R6: While write-enable is set and done is clear, each write to offset 0x28 pulses coef_we in that same cycle. coef_wdata carries the low 16 bits of the write, and coef_waddr counts 0, 1, 2, … with each accepted write.
- R7: The done flag (control bit 2) reads 1 from the cycle after the 128th accepted tap write and not before. Writes cannot change bit 2.
- R8: Once done is set, further writes to 0x28 produce no coef_we until write-enable rises again.
- R9: Writes to 0x28 while write-enable is clear produce no coef_we and do not advance the address. Reading 0x28 returns 0.
- R10: Bit 0 of the interrupt status word (0x18) is set when a load completes. Writing 1 to that bit clears it. Bit 0 of 0x1C is the enable, and irq equals status AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| coef_we | output | 1 | Coefficient RAM write strobe |
| coef_waddr | output | 7 | Coefficient RAM tap address |
| coef_wdata | output | 16 | Coefficient value to store |
| gain_ch0 | output | 16 | Channel 0 gain |
| gain_ch1 | output | 16 | Channel 1 gain |
| tone_en | output | 1 | Sidetone enable |
| auto_idle | output | 1 | Permission to gate the clock while idle |
| irq | output | 1 | Load-complete interrupt |

## Verification
The assertions assume the bus carries at most one write per cycle, as the single strobe implies. They also assume that the tap port and the control word are written in separate cycles, so a load start never coincides with a tap write. The stimulus uses one write task that holds the strobe for exactly one cycle. Random data covers the gains and taps, and random start points cover partial loads. Directed cases cover writes with write-enable low, writes after done, restarting a load part-way through, and writing 1 to the read-only done bit.

// File: rtl/st_pkg.sv
package st_pkg;
    // Register byte offsets; software depends on these positions
    localparam int OFF_REV   = 'h00;
    localparam int OFF_CFG   = 'h10;
    localparam int OFF_IRQST = 'h18;
    localparam int OFF_IRQEN = 'h1C;
    localparam int OFF_GAIN  = 'h24;
    localparam int OFF_TAP   = 'h28;
    localparam int OFF_CTRL  = 'h2C;

    // Control word bit positions
    localparam int CTRL_TONE = 0;
    localparam int CTRL_WEN  = 1;
    localparam int CTRL_DONE = 2;

    // Snapshot of register state handed to the read multiplexer
    typedef struct packed {
        logic        auto_idle;
        logic        irq_st;
        logic        irq_en;
        logic        tone_en;
        logic        wen;
        logic [15:0] gain0;
        logic [15:0] gain1;
    } st_regs_t;
endpackage

// File: rtl/st_coef_loader.sv
// Tap loader: counts accepted writes to the tap port, drives the coefficient
// RAM write port and raises the done flag after the last tap.
// Assumes load_start and port_wr never occur in the same cycle (one bus).
module st_coef_loader #(
    parameter int NTAPS  = 128,
    parameter int COEF_W = 16,
    parameter int TAP_AW = $clog2(NTAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic              wr_enable,
    input  logic              port_wr,
    input  logic [COEF_W-1:0] port_data,
    output logic              coef_we,
    output logic [TAP_AW-1:0] coef_addr,
    output logic [COEF_W-1:0] coef_data,
    output logic              load_done,
    output logic              last_accept
);
    localparam logic [TAP_AW-1:0] LAST = TAP_AW'(NTAPS - 1);

    logic [TAP_AW-1:0] cnt;
    logic              done;

    // Accept a tap only inside an open, unfinished load
    always_comb begin
        coef_we     = port_wr && wr_enable && !done;
        coef_addr   = cnt;
        coef_data   = port_data;
        last_accept = coef_we && (cnt == LAST);
        load_done   = done;
    end

    // Tap counter and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (load_start) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (coef_we) begin
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
            done <= (cnt == LAST);
        end
    end

    p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> (coef_addr == '0 && !load_done));
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_we && coef_addr != LAST) |=> (coef_addr == $past(coef_addr) + 1'b1));
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_we && coef_addr == LAST) |=> load_done);
    p_no_write_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !coef_we);
    p_write_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |-> wr_enable);
endmodule

// File: rtl/st_regfile.sv
// Writable registers: gains, configuration, interrupt pair and the control
// bits. Produces the load-start pulse on a 0->1 write of write-enable.
// Assumes one bus write per cycle.
module st_regfile
    import st_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              load_complete,
    output st_regs_t          regs,
    output logic              load_start,
    output logic              port_wr
);
    logic hit_cfg, hit_ist, hit_ien, hit_gain, hit_ctrl;

    // Address decode of the write strobe
    always_comb begin
        hit_cfg    = bus_wr && bus_addr == ADDR_W'(OFF_CFG);
        hit_ist    = bus_wr && bus_addr == ADDR_W'(OFF_IRQST);
        hit_ien    = bus_wr && bus_addr == ADDR_W'(OFF_IRQEN);
        hit_gain   = bus_wr && bus_addr == ADDR_W'(OFF_GAIN);
        hit_ctrl   = bus_wr && bus_addr == ADDR_W'(OFF_CTRL);
        port_wr    = bus_wr && bus_addr == ADDR_W'(OFF_TAP);
        load_start = hit_ctrl && bus_wdata[CTRL_WEN] && !regs.wen;
    end

    // Register updates; a completing load wins over a clear of the status bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            if (hit_cfg)  regs.auto_idle <= bus_wdata[0];
            if (hit_ien)  regs.irq_en    <= bus_wdata[0];
            if (hit_gain) begin
                regs.gain0 <= bus_wdata[15:0];
                regs.gain1 <= bus_wdata[31:16];
            end
            if (hit_ctrl) begin
                regs.tone_en <= bus_wdata[CTRL_TONE];
                regs.wen     <= bus_wdata[CTRL_WEN];
            end
            if (load_complete)                regs.irq_st <= 1'b1;
            else if (hit_ist && bus_wdata[0]) regs.irq_st <= 1'b0;
        end
    end

    p_gain_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_gain |=> (regs.gain0 == $past(bus_wdata[15:0]) &&
                      regs.gain1 == $past(bus_wdata[31:16])));
    p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_complete |=> regs.irq_st);
endmodule

// File: rtl/st_rdmux.sv
// Combinational read multiplexer. Unmapped offsets and the tap port read 0.
module st_rdmux
    import st_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [31:0] REV_ID = 32'h0001_0003
) (
    input  logic [ADDR_W-1:0] addr,
    input  st_regs_t          regs,
    input  logic              done,
    output logic [31:0]       rdata
);
    // Select the word for the current offset
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_REV):   rdata = REV_ID;
            ADDR_W'(OFF_CFG):   rdata = {31'b0, regs.auto_idle};
            ADDR_W'(OFF_IRQST): rdata = {31'b0, regs.irq_st};
            ADDR_W'(OFF_IRQEN): rdata = {31'b0, regs.irq_en};
            ADDR_W'(OFF_GAIN):  rdata = {regs.gain1, regs.gain0};
            ADDR_W'(OFF_CTRL):  rdata = {29'b0, done, regs.wen, regs.tone_en};
            default:            rdata = '0;
        endcase
    end
endmodule

// File: rtl/sidetone_ctrl.sv
// Sidetone control top: register bus, tap loader and control outputs.
// Assumes one write per cycle and a synchronous active-low reset.
module sidetone_ctrl
    import st_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          NTAPS  = 128,
    parameter int          COEF_W = 16,
    parameter logic [31:0] REV_ID = 32'h0001_0003,
    localparam int         TAP_AW = $clog2(NTAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              coef_we,
    output logic [TAP_AW-1:0] coef_waddr,
    output logic [COEF_W-1:0] coef_wdata,
    output logic [15:0]       gain_ch0,
    output logic [15:0]       gain_ch1,
    output logic              tone_en,
    output logic              auto_idle,
    output logic              irq
);
    st_regs_t regs;
    logic     load_start, port_wr, load_done, last_accept;

    st_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .load_complete(last_accept), .regs(regs),
        .load_start(load_start), .port_wr(port_wr)
    );

    st_coef_loader #(.NTAPS(NTAPS), .COEF_W(COEF_W), .TAP_AW(TAP_AW)) u_load (
        .clk(clk), .rst_n(rst_n), .load_start(load_start), .wr_enable(regs.wen),
        .port_wr(port_wr), .port_data(bus_wdata[COEF_W-1:0]), .coef_we(coef_we),
        .coef_addr(coef_waddr), .coef_data(coef_wdata), .load_done(load_done),
        .last_accept(last_accept)
    );

    st_rdmux #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_rd (
        .addr(bus_addr), .regs(regs), .done(load_done), .rdata(bus_rdata)
    );

    // Drive control outputs from the register state
    always_comb begin
        gain_ch0  = regs.gain0;
        gain_ch1  = regs.gain1;
        tone_en   = regs.tone_en;
        auto_idle = regs.auto_idle;
        irq       = regs.irq_st && regs.irq_en;
    end

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> regs.irq_en);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!tone_en && !irq && !auto_idle && gain_ch0 == '0));
    p_rev_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_REV)) |-> (bus_rdata == REV_ID));
endmodule

// File: tb/sidetone_ctrl_test.sv
`timescale 1ns/1ps
module sidetone_ctrl_test;
    localparam logic [31:0] REV = 32'h0001_0003;
    localparam int NT = 128;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        coef_we;
    logic [6:0]  coef_waddr;
    logic [15:0] coef_wdata, gain_ch0, gain_ch1;
    logic        tone_en, auto_idle, irq;

    int n_chk = 0;
    int n_bad = 0;

    sidetone_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .coef_we(coef_we),
        .coef_waddr(coef_waddr), .coef_wdata(coef_wdata), .gain_ch0(gain_ch0),
        .gain_ch1(gain_ch1), .tone_en(tone_en), .auto_idle(auto_idle), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(bit done, bit wen, bit ten);
        return {29'b0, done, wen, ten};
    endfunction

    // One-cycle write; returns at the falling edge after the accepting edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Tap write that checks the RAM port in the same cycle
    task automatic tap(logic [31:0] d, bit exp_we, int exp_addr, string req);
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h28; bus_wdata = d;
        #1;
        check(req, {31'b0, coef_we}, {31'b0, exp_we});
        if (exp_we) begin
            check(req, {25'b0, coef_waddr}, exp_addr);
            check(req, {16'b0, coef_wdata}, {16'b0, d[15:0]});
        end
        @(negedge clk);
        bus_wr = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r, g;
        int k;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        rd(8'h2C, r); check("R1 ctrl", r, 0);
        check("R1 outs", {gain_ch1, gain_ch0}, 0);
        check("R1 bits", {tone_en, auto_idle, irq}, 0);
        // R2 revision
        rd(8'h00, r); check("R2 rev", r, REV);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, r); check("R2 rev after write", r, REV);
        // R3 random gains
        for (int i = 0; i < 6; i++) begin
            g = $urandom;
            wr(8'h24, g);
            check("R3 gain0", {16'b0, gain_ch0}, {16'b0, g[15:0]});
            check("R3 gain1", {16'b0, gain_ch1}, {16'b0, g[31:16]});
            rd(8'h24, r); check("R3 readback", r, g);
        end
        // R4 enables
        wr(8'h10, 1); check("R4 auto_idle", {31'b0, auto_idle}, 1);
        rd(8'h10, r); check("R4 cfg read", r, 1);
        wr(8'h10, 0); check("R4 auto_idle off", {31'b0, auto_idle}, 0);
        wr(8'h2C, 1); check("R4 tone_en", {31'b0, tone_en}, 1);
        rd(8'h2C, r); check("R4 ctrl read", r, ctrl_word(0, 0, 1));
        // R9 writes while enable clear
        tap(32'h1111, 0, 0, "R9 dropped");
        rd(8'h28, r); check("R9 port reads 0", r, 0);
        // R5/R6/R7 full load
        wr(8'h2C, 32'h3);
        rd(8'h2C, r); check("R5 done clear", r, ctrl_word(0, 1, 1));
        for (int i = 0; i < NT; i++) begin
            tap($urandom, 1, i, "R6 tap");
            if (i == NT - 2) begin
                rd(8'h2C, r); check("R7 not yet done", r, ctrl_word(0, 1, 1));
            end
        end
        rd(8'h2C, r); check("R7 done", r, ctrl_word(1, 1, 1));
        // R8 writes after done
        tap(32'h2222, 0, 0, "R8 ignored");
        tap(32'h3333, 0, 0, "R8 ignored again");
        // R7 done read-only
        wr(8'h2C, 32'h7);
        rd(8'h2C, r); check("R7 done read-only", r, ctrl_word(1, 1, 1));
        wr(8'h2C, 32'h5);
        rd(8'h2C, r); check("R7 bit2 write ignored", r, ctrl_word(1, 0, 1));
        // R10 interrupt
        rd(8'h18, r); check("R10 status set", r, 1);
        check("R10 irq masked", {31'b0, irq}, 0);
        wr(8'h1C, 1); check("R10 irq on", {31'b0, irq}, 1);
        wr(8'h18, 1); check("R10 w1c", {31'b0, irq}, 0);
        rd(8'h18, r); check("R10 status clear", r, 0);
        // R5 restart mid-load
        wr(8'h2C, 32'h2);
        rd(8'h2C, r); check("R5 restart done clear", r, ctrl_word(0, 1, 0));
        k = 1 + ($urandom % 40);
        for (int i = 0; i < k; i++) tap($urandom, 1, i, "R6 partial");
        wr(8'h2C, 32'h0);
        tap(32'h4444, 0, 0, "R9 after disable");
        wr(8'h2C, 32'h2);
        tap(32'h5A5A, 1, 0, "R5 address back to 0");
        tap(32'hA5A5, 1, 1, "R6 next address");
        // R1 reset mid-operation
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        rd(8'h2C, r); check("R1 ctrl after reset", r, 0);
        check("R1 gains after reset", {gain_ch1, gain_ch0}, 0);
        tap(32'h6666, 0, 0, "R1 wen cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule